// File: doc/BRIEF.md
# Gated Binary Decoder with Data-Distributor Channel

This block turns a 3-bit binary code into a choice of one line out of eight. The selected line is pulled low and the other seven stay high. Three enable pins with mixed polarity gate the decode. One enable is active high and two are active low. Unless all three are at their active level, every output line rests high and the code is ignored. The logic is purely combinational: the outputs follow the inputs in the same cycle, with no clock or state inside the block.

The top carries two channels. The first is the plain decoder with all three enables brought out. The second is a data distributor built from the same decode core. It ties the active-high enable to 1 and one active-low enable to 0, and it feeds a serial data bit into the remaining active-low enable. The addressed line then repeats the data bit and every other line stays high. This suits fan-out of one serial signal to one of eight active-low consumers.

Top module: `gated_decoder_top`

## Requirements
- R1: Selects are active high and outputs active low. When enabled, output line `dec_out_n[k]` is 0 exactly for k equal to the unsigned value of `dec_sel`, with bit 0 as the least significant bit.
- R2: The decoder is enabled only when `dec_en_hi` is 1 and both `dec_en_a_n` and `dec_en_b_n` are 0.
- R3: If any enable is at its inactive level, `dec_out_n` is 8'hFF whatever `dec_sel` holds.
- R4: When enabled, select value 7 (binary 111) drives only `dec_out_n[7]` low, and select value 6 (binary 110) drives only `dec_out_n[6]` low.
- R5: When enabled, exactly one bit of `dec_out_n` is 0. When disabled, none is.
- R6: On the distributor channel, `dmx_out_n[dmx_sel]` equals `dmx_data` for every select value.
- R7: On the distributor channel, every line other than the one addressed by `dmx_sel` stays at 1 for both data values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_sel | input | 3 | Binary code for the decoder channel, active high |
| dec_en_hi | input | 1 | Decoder enable, active high |
| dec_en_a_n | input | 1 | Decoder enable, active low |
| dec_en_b_n | input | 1 | Decoder enable, active low |
| dec_out_n | output | 8 | Decoder lines, one low when enabled |
| dmx_sel | input | 3 | Address of the distributor line |
| dmx_data | input | 1 | Serial data bit to distribute |
| dmx_out_n | output | 8 | Distributor lines, addressed line repeats data |

## Verification
The block holds no state. A fault in the enable combination or in the decode compare therefore shows at the ports in the same evaluation as the input change that exposes it. A wrong enable term shows up as a low line while disabled, or as all lines high while enabled. A wrong index compare shows up as the wrong line low, or as two lines low at once. The sweep covers all 64 combinations of the three select bits and the three enables, plus both data values at every distributor address. Any such fault is therefore visible at its first offending input pattern.

// File: rtl/gated_decoder_pkg.sv
package gated_decoder_pkg;
    localparam int unsigned CODE_W  = 3;
    localparam int unsigned LINE_N  = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [LINE_N-1:0] lines_t;

    // Combinational result bundle of the decode core.
    typedef struct packed {
        logic   enabled;
        lines_t lines_n;
    } dec_result_t;
endpackage

// File: rtl/dec_enable_gate.sv
module dec_enable_gate #(
    parameter int unsigned HI_N = 1,
    parameter int unsigned LO_N = 2
) (
    input  logic [HI_N-1:0] en_hi_i,
    input  logic [LO_N-1:0] en_lo_n_i,
    output logic            enabled_o
);
    logic all_hi_d;
    logic all_lo_d;

    always_comb begin
        all_hi_d  = &en_hi_i;
        all_lo_d  = ~(|en_lo_n_i);
        enabled_o = all_hi_d & all_lo_d;
    end

    // R3: a single inactive enable must keep the gate shut
    always_comb begin
        if (!$isunknown({en_hi_i, en_lo_n_i}) && ((en_lo_n_i != '0) || (en_hi_i != '1)))
            assert_gate_shut_R3: assert (enabled_o == 1'b0)
                else $error("gate open with an inactive enable");
    end
endmodule

// File: rtl/dec_line_driver.sv
module dec_line_driver #(
    parameter int unsigned CODE_W = 3,
    localparam int unsigned LINE_N = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              enabled_i,
    output logic [LINE_N-1:0] lines_n_o
);
    for (genvar k = 0; k < LINE_N; k++) begin : g_line
        localparam logic [CODE_W-1:0] MATCH = CODE_W'(k);
        logic hit_d;
        always_comb begin
            hit_d        = enabled_i && (code_i == MATCH);
            lines_n_o[k] = ~hit_d;
        end
    end

    // R5: at most one line low at any time
    always_comb begin
        if (!$isunknown({code_i, enabled_i}))
            assert_onehot_low_R5: assert ($onehot0(~lines_n_o))
                else $error("more than one line low");
    end
endmodule

// File: rtl/dec_core.sv
module dec_core
    import gated_decoder_pkg::*;
(
    input  code_t  code_i,
    input  logic   en_hi_i,
    input  logic   en_a_n_i,
    input  logic   en_b_n_i,
    output lines_t lines_n_o
);
    dec_result_t res_d;
    logic        enabled_w;
    lines_t      lines_w;

    dec_enable_gate #(
        .HI_N (1),
        .LO_N (2)
    ) u_gate (
        .en_hi_i   (en_hi_i),
        .en_lo_n_i ({en_b_n_i, en_a_n_i}),
        .enabled_o (enabled_w)
    );

    dec_line_driver #(
        .CODE_W (CODE_W)
    ) u_lines (
        .code_i    (code_i),
        .enabled_i (enabled_w),
        .lines_n_o (lines_w)
    );

    always_comb begin
        res_d.enabled = enabled_w;
        res_d.lines_n = lines_w;
        lines_n_o     = res_d.lines_n;
    end

    // R2, R5: enabled means exactly one low line, disabled means none
    always_comb begin
        if (!$isunknown({code_i, en_hi_i, en_a_n_i, en_b_n_i}))
            assert_low_count_R2: assert ($countones(~lines_n_o) ==
                                         ((en_hi_i && !en_a_n_i && !en_b_n_i) ? 1 : 0))
                else $error("low line count disagrees with enables");
    end

    // R1: the low line sits at the code index
    always_comb begin
        if (!$isunknown({code_i, en_hi_i, en_a_n_i, en_b_n_i}) &&
            en_hi_i && !en_a_n_i && !en_b_n_i)
            assert_index_R1: assert (lines_n_o[code_i] == 1'b0)
                else $error("addressed line not low");
    end
endmodule

// File: rtl/dec_distributor.sv
module dec_distributor
    import gated_decoder_pkg::*;
(
    input  code_t  addr_i,
    input  logic   data_i,
    output lines_t lines_n_o
);
    dec_core u_core (
        .code_i    (addr_i),
        .en_hi_i   (1'b1),
        .en_a_n_i  (data_i),
        .en_b_n_i  (1'b0),
        .lines_n_o (lines_n_o)
    );

    // R6: addressed line repeats the data bit
    always_comb begin
        if (!$isunknown({addr_i, data_i}))
            assert_follow_R6: assert (lines_n_o[addr_i] == data_i)
                else $error("addressed line does not follow data");
    end

    // R7: all other lines high
    always_comb begin
        if (!$isunknown({addr_i, data_i}))
            assert_idle_high_R7: assert (($countones(lines_n_o) == LINE_N - 1) ||
                                         (lines_n_o == '1))
                else $error("unaddressed line low");
    end
endmodule

// File: rtl/gated_decoder_top.sv
module gated_decoder_top (
    input  logic [2:0] dec_sel,
    input  logic       dec_en_hi,
    input  logic       dec_en_a_n,
    input  logic       dec_en_b_n,
    output logic [7:0] dec_out_n,
    input  logic [2:0] dmx_sel,
    input  logic       dmx_data,
    output logic [7:0] dmx_out_n
);
    dec_core u_dec (
        .code_i    (dec_sel),
        .en_hi_i   (dec_en_hi),
        .en_a_n_i  (dec_en_a_n),
        .en_b_n_i  (dec_en_b_n),
        .lines_n_o (dec_out_n)
    );

    dec_distributor u_dmx (
        .addr_i    (dmx_sel),
        .data_i    (dmx_data),
        .lines_n_o (dmx_out_n)
    );

    // R3: any inactive enable leaves every line high
    always_comb begin
        if (!$isunknown({dec_en_hi, dec_en_a_n, dec_en_b_n}) &&
            (!dec_en_hi || dec_en_a_n || dec_en_b_n))
            assert_all_high_R3: assert (dec_out_n == 8'hFF)
                else $error("line low while disabled");
    end
endmodule

// File: tb/tb_gated_decoder_top.sv
module tb_gated_decoder_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dec_sel;
    logic       dec_en_hi, dec_en_a_n, dec_en_b_n;
    logic [7:0] dec_out_n;
    logic [2:0] dmx_sel;
    logic       dmx_data;
    logic [7:0] dmx_out_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gated_decoder_top dut (
        .dec_sel    (dec_sel),
        .dec_en_hi  (dec_en_hi),
        .dec_en_a_n (dec_en_a_n),
        .dec_en_b_n (dec_en_b_n),
        .dec_out_n  (dec_out_n),
        .dmx_sel    (dmx_sel),
        .dmx_data   (dmx_data),
        .dmx_out_n  (dmx_out_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [2:0] s, input bit on);
        logic [7:0] v;
        v = 8'hFF;
        if (on) v[s] = 1'b0;
        return v;
    endfunction

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        dec_sel = 3'd0; dec_en_hi = 1'b0; dec_en_a_n = 1'b1; dec_en_b_n = 1'b1;
        dmx_sel = 3'd0; dmx_data = 1'b1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset decoder", dec_out_n, 8'hFF);
        check("R7 reset distributor", dmx_out_n, 8'hFF);

        // exhaustive sweep: 3 selects x 3 enables
        for (int c = 0; c < 64; c++) begin
            bit on;
            @(posedge clk);
            {dec_en_b_n, dec_en_a_n, dec_en_hi, dec_sel} = 6'(c);
            @(negedge clk);
            on = (dec_en_hi == 1'b1) && (dec_en_a_n == 1'b0) && (dec_en_b_n == 1'b0);
            if (on) begin
                check("R1 R2 enabled decode", dec_out_n, model(dec_sel, 1'b1));
                check("R5 one low when enabled", 8'($countones(~dec_out_n)), 8'd1);
            end else begin
                check("R3 disabled all high", dec_out_n, 8'hFF);
                check("R5 none low when disabled", 8'($countones(~dec_out_n)), 8'd0);
            end
        end

        // R4 explicit corner codes
        @(posedge clk);
        dec_en_hi = 1'b1; dec_en_a_n = 1'b0; dec_en_b_n = 1'b0; dec_sel = 3'b111;
        @(negedge clk);
        check("R4 code 7", dec_out_n, 8'b0111_1111);
        @(posedge clk);
        dec_sel = 3'b110;
        @(negedge clk);
        check("R4 code 6", dec_out_n, 8'b1011_1111);
        // R2 each enable alone inactive with code 6
        @(posedge clk);
        dec_en_hi = 1'b0;
        @(negedge clk);
        check("R2 hi enable low", dec_out_n, 8'hFF);
        @(posedge clk);
        dec_en_hi = 1'b1; dec_en_b_n = 1'b1;
        @(negedge clk);
        check("R2 b enable high", dec_out_n, 8'hFF);

        // distributor: both data values at every address
        for (int a = 0; a < 8; a++) begin
            for (int d = 0; d < 2; d++) begin
                logic [7:0] exp;
                @(posedge clk);
                dmx_sel = 3'(a);
                dmx_data = d[0];
                @(negedge clk);
                exp = 8'hFF;
                exp[a] = d[0];
                check("R6 R7 distributor lines", dmx_out_n, exp);
                check("R6 addressed line", {7'd0, dmx_out_n[a]}, {7'd0, d[0]});
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule